// File: doc/BRIEF.md
# Staggered DRAM Power-Down Stepper

This block decides when a DRAM device enters and leaves its low-power modes. It has no idle timer. While the memory controller reports that it is idle, every refresh tick sends the device one level deeper. The first tick enters active power-down. The second moves it to precharge power-down, closing any open banks on the way. The third puts it into self-refresh.

Self-refresh entry always begins with an internal refresh inside the device, so entering it early wastes energy. Tying each step to the refresh cadence means the device reaches self-refresh only after two full refresh intervals of idleness. A timer-based policy would instead need a counter of several hundred cycles for each mode.

A pending request wakes the device from any low-power level. The block issues the matching exit command and holds `ready` low for an exit latency that depends on the level being left. Refresh ticks are forwarded to the refresh engine in every state except self-refresh and the wake-up transient.

Top module: `dram_pd_stepper`

## Requirements
- R1: After reset, `state` is 0 (run), `ready` is 1, `cmd` is 0 and `ref_out` is 0.
- R2: In run (state 0), a refresh tick with `idle` high and `req_pend` low moves the block to active power-down (state 1) and issues `cmd` 1 on the following cycle. A tick with `idle` low leaves it in run with `cmd` 0.
- R3: In active power-down, a tick without a request moves the block to precharge power-down (state 2). With `bank_open` low, `cmd` is 2. With `bank_open` high, `cmd` is 3, meaning precharge-all followed by entry.
- R4: In precharge power-down, a tick without a request moves the block to self-refresh (state 3) with `cmd` 4.
- R5: In self-refresh, a refresh tick has no effect: the state stays 3, `cmd` stays 0 and `ref_out` stays 0. In states 0, 1 and 2, a tick produces a one-cycle `ref_out` pulse on the next cycle.
- R6: With no tick and no request, the state never changes, however long the block stays idle (no timeout).
- R7: `req_pend` in state 1 or 2 moves the block to wake (state 4) with `cmd` 5. In state 3 it moves the block to wake with `cmd` 6. A request takes precedence over a tick in the same cycle and has no effect in run.
- R8: `ready` is high only in run. After entering wake, the block returns to run after exactly `LAT_APD`, `LAT_PPD` or `LAT_SELF` cycles, according to the level it left.
- R9: `cmd` is a one-cycle pulse and returns to 0 unless another transition occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle | input | 1 | Controller has no queued work |
| bank_open | input | 1 | At least one bank holds an open row |
| ref_tick | input | 1 | Periodic refresh event, one cycle wide |
| req_pend | input | 1 | New access waiting for the device |
| cmd | output | 3 | Power command: 0 none, 1 enter active PD, 2 enter precharge PD, 3 precharge-all plus precharge PD, 4 enter self-refresh, 5 exit PD, 6 exit self-refresh |
| ref_out | output | 1 | Forwarded refresh request |
| state | output | 3 | 0 run, 1 active PD, 2 precharge PD, 3 self-refresh, 4 wake |
| ready | output | 1 | Device may accept accesses |

## Verification
The assertions assume that `ref_tick` is a single-cycle pulse. They also assume that `req_pend`, once raised, stays high until `ready` returns, so that a wake sequence is never abandoned halfway. The stimulus drives `ref_tick` for exactly one cycle per step. It holds the request through the whole latency count and drops it only after `ready` is seen high. The stimulus lowers `idle` whenever a request is present, except in the one case that checks `idle` itself.

// File: rtl/dram_pd_stepper.sv
module dram_pd_stepper #(
  parameter int LAT_APD  = 2,
  parameter int LAT_PPD  = 3,
  parameter int LAT_SELF = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle,
  input  logic       bank_open,
  input  logic       ref_tick,
  input  logic       req_pend,
  output logic [2:0] cmd,
  output logic       ref_out,
  output logic [2:0] state,
  output logic       ready
);
  localparam int LAT_MAX = (LAT_SELF > LAT_PPD) ? ((LAT_SELF > LAT_APD) ? LAT_SELF : LAT_APD)
                                                : ((LAT_PPD > LAT_APD) ? LAT_PPD : LAT_APD);
  localparam int CW = $clog2(LAT_MAX + 1);

  localparam logic [2:0] ST_RUN = 3'd0, ST_APD = 3'd1, ST_PPD = 3'd2, ST_SELF = 3'd3, ST_WAKE = 3'd4;
  localparam logic [2:0] C_NONE = 3'd0, C_APD_IN = 3'd1, C_PPD_IN = 3'd2, C_PREA_PPD = 3'd3,
                         C_SELF_IN = 3'd4, C_PD_OUT = 3'd5, C_SELF_OUT = 3'd6;

  logic [2:0]    nxt_state, nxt_cmd;
  logic [CW-1:0] cnt, nxt_cnt;

  assign ready = (state == ST_RUN);

  always_comb begin
    nxt_state = state;
    nxt_cmd   = C_NONE;
    nxt_cnt   = cnt;
    case (state)
      ST_RUN:
        if (ref_tick && idle && !req_pend) begin
          nxt_state = ST_APD;
          nxt_cmd   = C_APD_IN;
        end
      ST_APD:
        if (req_pend) begin
          nxt_state = ST_WAKE;
          nxt_cmd   = C_PD_OUT;
          nxt_cnt   = CW'(LAT_APD - 1);
        end else if (ref_tick) begin
          nxt_state = ST_PPD;
          nxt_cmd   = bank_open ? C_PREA_PPD : C_PPD_IN;
        end
      ST_PPD:
        if (req_pend) begin
          nxt_state = ST_WAKE;
          nxt_cmd   = C_PD_OUT;
          nxt_cnt   = CW'(LAT_PPD - 1);
        end else if (ref_tick) begin
          nxt_state = ST_SELF;
          nxt_cmd   = C_SELF_IN;
        end
      ST_SELF:
        if (req_pend) begin
          nxt_state = ST_WAKE;
          nxt_cmd   = C_SELF_OUT;
          nxt_cnt   = CW'(LAT_SELF - 1);
        end
      ST_WAKE:
        if (cnt == '0) nxt_state = ST_RUN;
        else           nxt_cnt   = cnt - 1'b1;
      default: nxt_state = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_RUN;
      cmd     <= C_NONE;
      cnt     <= '0;
      ref_out <= 1'b0;
    end else begin
      state   <= nxt_state;
      cmd     <= nxt_cmd;
      cnt     <= nxt_cnt;
      ref_out <= ref_tick && (state == ST_RUN || state == ST_APD || state == ST_PPD);
    end
  end

  AST_RUN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |=> (state == ST_RUN || state == ST_APD)); // R2
  AST_PREA_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_APD && ref_tick && !req_pend && bank_open) |=> (cmd == C_PREA_PPD && state == ST_PPD)); // R3
  AST_SELF_NO_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SELF) |=> !ref_out); // R5
  AST_NO_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_WAKE && !ref_tick && !req_pend) |=> $stable(state)); // R6
  AST_REQ_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pend && (state == ST_APD || state == ST_PPD || state == ST_SELF)) |=> (state == ST_WAKE && cmd != C_NONE)); // R7
  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != C_NONE && !ref_tick && !req_pend) |=> (cmd == C_NONE)); // R9
endmodule

// File: tb/sim_dram_pd_stepper.sv
`timescale 1ns/1ps
module sim_dram_pd_stepper;
  localparam int LA = 2, LP = 3, LS = 6;
  logic clk = 0, rst_n = 0, idle = 0, bank_open = 0, ref_tick = 0, req_pend = 0;
  logic [2:0] cmd, state;
  logic ref_out, ready;
  int checks = 0, errors = 0;
  bit done = 0;

  dram_pd_stepper #(.LAT_APD(LA), .LAT_PPD(LP), .LAT_SELF(LS)) u0 (
    .clk(clk), .rst_n(rst_n), .idle(idle), .bank_open(bank_open), .ref_tick(ref_tick),
    .req_pend(req_pend), .cmd(cmd), .ref_out(ref_out), .state(state), .ready(ready));

  always #10 clk = ~clk;

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic step(bit t, bit rq, bit idl);
    @(negedge clk);
    ref_tick = t; req_pend = rq; idle = idl;
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 state", state, 0); chk("R1 ready", ready, 1);
    chk("R1 cmd", cmd, 0);     chk("R1 ref_out", ref_out, 0);
    @(negedge clk) rst_n = 1;

    step(1, 0, 0);
    chk("R2 busy state", state, 0); chk("R2 busy cmd", cmd, 0); chk("R5 ref fwd", ref_out, 1);
    step(0, 0, 1);

    for (int coinc = 0; coinc < 2; coinc++)
      for (int bo = 0; bo < 2; bo++)
        for (int d = 0; d < 4; d++) begin
          int lat;
          bank_open = bo[0];
          for (int k = 1; k <= d; k++) begin
            step(1, 0, 1);
            chk("R2 R3 R4 state", state, k);
            chk("R2 R3 R4 cmd", cmd, (k == 1) ? 1 : (k == 2) ? (bo ? 3 : 2) : 4);
            chk("R5 ref fwd", ref_out, 1);
            chk("R8 ready", ready, 0);
            step(0, 0, 1);
            chk("R9 pulse", cmd, 0);
          end
          for (int i = 0; i < ((d == 3) ? 520 : 20); i++) step(0, 0, 1);
          chk("R6 hold", state, d);
          if (d == 3) begin
            step(1, 0, 1);
            chk("R5 self state", state, 3); chk("R5 self ref", ref_out, 0); chk("R5 self cmd", cmd, 0);
          end
          step(coinc[0], 1, 0);
          if (d == 0) begin
            chk("R7 run req", state, 0); chk("R7 run cmd", cmd, 0); chk("R8 run ready", ready, 1);
          end else begin
            lat = (d == 1) ? LA : (d == 2) ? LP : LS;
            chk("R7 wake state", state, 4);
            chk("R7 exit cmd", cmd, (d == 3) ? 6 : 5);
            chk("R8 wake ready", ready, 0);
            for (int i = 1; i <= lat; i++) begin
              step(0, 1, 0);
              chk("R8 latency ready", ready, (i == lat) ? 1 : 0);
            end
            chk("R8 back to run", state, 0);
          end
          step(0, 0, 1);
        end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule